// File: doc/BRIEF.md
# SPI Register Access Slave

This block is an SPI slave that lets a host reach a 64-entry byte register file and an 8-deep byte FIFO. It runs in the system clock domain and oversamples the serial clock, the chip select and the data in. Every transaction opens with a command byte. Its most significant bit picks the direction. Bits [6:1] give a six-bit register address, and bit 0 is reserved.

A read burst is pipelined. Each later MOSI byte names another register, and the MISO byte sent during that same MOSI byte carries the data for the address named one byte earlier. An all-zero MOSI byte asks for nothing new and closes the burst. A write burst sends every data byte to the one address from the command byte, with no increment. A host can therefore stream any number of bytes into the FIFO address, which pushes each byte into the FIFO. Reading the FIFO address pops one entry.

Top module: `spi_reg_slave`

## Requirements
- R1: SPI mode 0 is used. MOSI is sampled on rising SCLK edges and MISO changes only after falling edges. Both directions shift the most significant bit first.
- R2: In the first byte after csN falls, bit 7 = 1 selects a read and bit 7 = 0 selects a write. A read never modifies any register.
- R3: Only bits [6:1] of an address byte form the address. A 1 in reserved bit 0, or in bit 7 of a later read address byte, is ignored.
- R4: In a read, the MISO byte shifted out during MOSI byte k is the data of the address carried in MOSI byte k-1.
- R5: An all-zero MOSI byte after the command byte of a read carries no address. The MISO byte that follows it is 0x00, and it pops nothing from the FIFO.
- R6: In a write, every data byte goes to the address from the command byte, with no address increment. Any number of data bytes is accepted, and the last one written stays in the register.
- R7: During a write transaction MISO stays low, so every MISO byte reads 0x00.
- R8: The FIFO address is 2 (parameter FIFO_ADDR). Writes to it push into an 8-entry FIFO (parameter FIFO_DEPTH), and reads of it pop entries in first-in, first-out order.
- R9: Reading the FIFO address while the FIFO is empty returns 0x00.
- R10: A push into a full FIFO drops the byte and sets fifoOverflow. fifoOverflow stays set until reset.
- R11: csN going high aborts the transaction and clears the bit counter. A partial byte has no effect, and the next transaction decodes a fresh command byte.
- R12: After reset, miso and fifoOverflow are 0 and every register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| csN | input | 1 | Active-low chip select that frames a transaction |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| fifoOverflow | output | 1 | Sticky flag set when a push hits a full FIFO |

## Verification
Read bursts are run with several address sequences. One mixes registers in arbitrary order, which tells true per-byte addressing apart from auto-increment. Another places a zero byte early, which tells the terminator apart from a request for register 0. A third sets the reserved bits, which shows that only bits [6:1] decode. Multi-byte writes to an ordinary register, followed by reads of it and of its neighbour, separate a fixed address from an incrementing one. FIFO streams of three, two and nine bytes separate correct ordering, a terminator that pops nothing, an empty read, and an overflow that drops bytes. Partial-byte aborts followed by a normal transaction show that the bit counter restarts.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_RD  = 2'd1,
    PH_WR  = 2'd2
  } phase_e;

  // strobes from control to datapath, at most one SCLK event per cycle
  typedef struct packed {
    logic idle;     // chip select inactive
    logic sample;   // rising SCLK: shift MOSI in
    logic cmdRd;    // command byte complete, read
    logic cmdWr;    // command byte complete, write
    logic rdNext;   // later read address byte complete
    logic wrData;   // write data byte complete
    logic loadTx;   // falling SCLK at byte boundary
    logic shiftTx;  // falling SCLK inside a byte
  } strobe_t;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    csN,
  input  logic    mosi,
  output strobe_t strb,
  output logic    mosiBit
);
  logic [SYNC_STAGES-1:0] sclkSh, csSh, mosiSh;
  logic sclkS, sclkQ, csActive, rise, fall, byteEnd, cmdBit;
  logic [2:0] bitCnt;
  phase_e phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSh <= '0;
      csSh   <= '1;
      mosiSh <= '0;
      sclkQ  <= 1'b0;
    end else begin
      sclkSh <= {sclkSh[SYNC_STAGES-2:0], sclk};
      csSh   <= {csSh[SYNC_STAGES-2:0], csN};
      mosiSh <= {mosiSh[SYNC_STAGES-2:0], mosi};
      sclkQ  <= sclkS;
    end
  end

  assign sclkS    = sclkSh[SYNC_STAGES-1];
  assign mosiBit  = mosiSh[SYNC_STAGES-1];
  assign csActive = !csSh[SYNC_STAGES-1];
  assign rise     = csActive && sclkS && !sclkQ;
  assign fall     = csActive && !sclkS && sclkQ;
  assign byteEnd  = rise && (bitCnt == 3'd7);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      phase  <= PH_CMD;
      cmdBit <= 1'b0;
    end else if (!csActive) begin
      bitCnt <= '0;
      phase  <= PH_CMD;
    end else if (rise) begin
      bitCnt <= bitCnt + 1'b1;
      if (phase == PH_CMD && bitCnt == 3'd0) cmdBit <= mosiBit;
      if (phase == PH_CMD && bitCnt == 3'd7) phase <= cmdBit ? PH_RD : PH_WR;
    end
  end

  always_comb begin
    strb         = '0;
    strb.idle    = !csActive;
    strb.sample  = rise;
    strb.cmdRd   = byteEnd && (phase == PH_CMD) && cmdBit;
    strb.cmdWr   = byteEnd && (phase == PH_CMD) && !cmdBit;
    strb.rdNext  = byteEnd && (phase == PH_RD);
    strb.wrData  = byteEnd && (phase == PH_WR);
    strb.loadTx  = fall && (bitCnt == 3'd0);
    strb.shiftTx = fall && (bitCnt != 3'd0);
  end
endmodule

// File: rtl/spi_reg_datapath.sv
module spi_reg_datapath
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 8,
  parameter int FIFO_ADDR  = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  logic    mosiBit,
  output logic    miso,
  output logic    fifoOverflow
);
  localparam int NREGS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] FIFO_SEL = FIFO_ADDR[ADDR_W-1:0];

  logic [7:0] regs [NREGS];
  logic [6:0] rxReg;
  logic [7:0] newByte, txReg, fifoHead, rdData;
  logic [ADDR_W-1:0] addrQ, pendAddr;
  logic pendValid, fifoFull, fifoEmpty, fifoPush, fifoPop, pendFifo;

  assign newByte  = {rxReg, mosiBit};
  assign pendFifo = (pendAddr == FIFO_SEL);
  assign fifoPush = strb.wrData && (addrQ == FIFO_SEL);
  assign fifoPop  = strb.loadTx && pendValid && pendFifo && !fifoEmpty;
  assign rdData   = !pendValid ? 8'h00 :
                    pendFifo   ? (fifoEmpty ? 8'h00 : fifoHead) :
                                 regs[pendAddr];
  assign miso     = txReg[7];

  spi_byte_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rstN  (rstN),
    .push  (fifoPush),
    .pop   (fifoPop),
    .din   (newByte),
    .dout  (fifoHead),
    .full  (fifoFull),
    .empty (fifoEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg        <= '0;
      addrQ        <= '0;
      pendAddr     <= '0;
      pendValid    <= 1'b0;
      txReg        <= '0;
      fifoOverflow <= 1'b0;
    end else begin
      if (strb.sample) rxReg <= newByte[6:0];
      if (strb.cmdWr) addrQ <= newByte[ADDR_W:1];
      if (strb.idle) begin
        pendValid <= 1'b0;
        txReg     <= '0;
      end else begin
        if (strb.cmdRd) begin
          pendAddr  <= newByte[ADDR_W:1];
          pendValid <= 1'b1;
        end else if (strb.rdNext) begin
          pendAddr  <= newByte[ADDR_W:1];
          pendValid <= (newByte != 8'h00);
        end else if (strb.loadTx) begin
          pendValid <= 1'b0;
        end
        if (strb.loadTx)       txReg <= rdData;
        else if (strb.shiftTx) txReg <= {txReg[6:0], 1'b0};
      end
      if (fifoPush && fifoFull) fifoOverflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (strb.wrData && (addrQ != FIFO_SEL)) begin
      regs[addrQ] <= newByte;
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int FIFO_DEPTH  = 8,
  parameter int FIFO_ADDR   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic mosi,
  output logic miso,
  output logic fifoOverflow
);
  strobe_t strb;
  logic mosiBit;

  spi_reg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclk    (sclk),
    .csN     (csN),
    .mosi    (mosi),
    .strb    (strb),
    .mosiBit (mosiBit)
  );

  spi_reg_datapath #(
    .ADDR_W     (ADDR_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .FIFO_ADDR  (FIFO_ADDR)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .mosiBit      (mosiBit),
    .miso         (miso),
    .fifoOverflow (fifoOverflow)
  );
endmodule

// File: rtl/spi_reg_checker.sv
module spi_reg_checker
  import spi_reg_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    miso,
  input logic    fifoOverflow,
  input strobe_t strb
);
  // R1
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadTx && !strb.shiftTx && !strb.idle) |=> $stable(miso));

  // R1
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sample, strb.loadTx, strb.shiftTx}));

  // R2
  byte_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.cmdRd, strb.cmdWr, strb.rdNext, strb.wrData}));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoOverflow |=> fifoOverflow);

  // R11
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.idle |=> !miso);
endmodule

bind spi_reg_slave spi_reg_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .miso         (miso),
  .fifoOverflow (fifoOverflow),
  .strb         (strb)
);

// File: tb/sim_spi_reg_slave.sv
`timescale 1ns/1ps
module sim_spi_reg_slave;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN, sclk, csN, mosi;
  logic miso, fifoOverflow;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  spi_reg_slave u0 (
    .clk          (clk),
    .rstN         (rstN),
    .sclk         (sclk),
    .csN          (csN),
    .mosi         (mosi),
    .miso         (miso),
    .fifoOverflow (fifoOverflow)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xferBits(input logic [7:0] txb, input int nbits, output logic [7:0] rxb);
    rxb = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = txb[i];
      repeat (HALF) @(negedge clk);
      rxb[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] txb, output logic [7:0] rxb);
    xferBits(txb, 8, rxb);
  endtask

  task automatic csStart();
    @(negedge clk);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csStop();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    mosi = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  // write n bytes of d to register a; MISO must read zero throughout (R7)
  task automatic writeBurst(input logic [5:0] a, input logic [7:0] d [10], input int n);
    logic [7:0] r;
    csStart();
    xfer({1'b0, a, 1'b0}, r);
    for (int i = 0; i < n; i++) begin
      xfer(d[i], r);
      check("R7 write miso", r, 8'h00);
    end
    csStop();
  endtask

  task automatic writeOne(input logic [5:0] a, input logic [7:0] v);
    logic [7:0] d [10];
    d = '{default: 8'h00};
    d[0] = v;
    writeBurst(a, d, 1);
  endtask

  task automatic readOne(input logic [5:0] a, output logic [7:0] v);
    logic [7:0] r;
    csStart();
    xfer({1'b1, a, 1'b0}, r);
    xfer(8'h00, v);
    csStop();
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R12 miso after reset", {7'b0, miso}, 8'h00);
    check("R12 overflow after reset", {7'b0, fifoOverflow}, 8'h00);
    readOne(6'd5, v);  check("R12 reg5 reset", v, 8'h00);
    readOne(6'd63, v); check("R12 reg63 reset", v, 8'h00);
  endtask

  task automatic testBasicRW();
    logic [7:0] v, r;
    writeOne(6'd5, 8'hA5);
    writeOne(6'd63, 8'h7E);
    readOne(6'd5, v);  check("R2 read reg5 (R1 msb first)", v, 8'hA5);
    readOne(6'd63, v); check("R2 read reg63", v, 8'h7E);
    csStart(); xfer(8'h8A, r); xfer(8'hFF, r); xfer(8'h00, r); csStop();
    readOne(6'd5, v);  check("R2 read leaves reg5", v, 8'hA5);
    readOne(6'd63, v); check("R2 read leaves reg63", v, 8'h7E);
  endtask

  task automatic testNoIncrement();
    logic [7:0] d [10];
    logic [7:0] v;
    d = '{default: 8'h00};
    d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
    writeBurst(6'd10, d, 3);
    readOne(6'd10, v); check("R6 last byte kept", v, 8'h33);
    readOne(6'd11, v); check("R6 neighbour untouched", v, 8'h00);
  endtask

  task automatic testReserved();
    logic [7:0] r, v;
    csStart(); xfer(8'h0D, r); xfer(8'h5C, r); csStop();
    readOne(6'd6, v); check("R3 write with bit0 set", v, 8'h5C);
    csStart(); xfer(8'h8D, r); xfer(8'h00, v); csStop();
    check("R3 read cmd with bit0 set", v, 8'h5C);
    csStart(); xfer(8'h8A, r); xfer(8'h8D, v); xfer(8'h00, r); csStop();
    check("R3 burst byte1", v, 8'hA5);
    check("R3 later byte bit7/bit0 ignored", r, 8'h5C);
  endtask

  task automatic testPipeline();
    logic [7:0] r0, r1, r2, r3, r4;
    csStart();
    xfer(8'h8A, r0); xfer(8'h14, r1); xfer(8'h0C, r2); xfer(8'h7E, r3); xfer(8'h00, r4);
    csStop();
    check("R4 byte1 reg5", r1, 8'hA5);
    check("R4 byte2 reg10", r2, 8'h33);
    check("R4 byte3 reg6", r3, 8'h5C);
    check("R4 byte4 reg63", r4, 8'h7E);
  endtask

  task automatic testZeroClose();
    logic [7:0] r0, r1, r2;
    csStart(); xfer(8'h8A, r0); xfer(8'h00, r1); xfer(8'h00, r2); csStop();
    check("R5 data before close", r1, 8'hA5);
    check("R5 after zero byte", r2, 8'h00);
  endtask

  task automatic testFifoOrder();
    logic [7:0] d [10];
    logic [7:0] r0, r1, r2, r3, r4, v;
    d = '{default: 8'h00};
    d[0] = 8'hC1; d[1] = 8'hC2; d[2] = 8'hC3;
    writeBurst(6'd2, d, 3);
    csStart();
    xfer(8'h84, r0); xfer(8'h04, r1); xfer(8'h04, r2); xfer(8'h04, r3); xfer(8'h00, r4);
    csStop();
    check("R8 fifo pop 1", r1, 8'hC1);
    check("R8 fifo pop 2", r2, 8'hC2);
    check("R8 fifo pop 3", r3, 8'hC3);
    check("R9 fifo empty read", r4, 8'h00);
    d[0] = 8'hD1; d[1] = 8'hD2;
    writeBurst(6'd2, d, 2);
    readOne(6'd2, v); check("R8 fifo D1", v, 8'hD1);
    readOne(6'd2, v); check("R5 zero byte did not pop", v, 8'hD2);
    readOne(6'd2, v); check("R9 empty again", v, 8'h00);
    check("R10 no overflow yet", {7'b0, fifoOverflow}, 8'h00);
  endtask

  task automatic testFifoOvf();
    logic [7:0] d [10];
    logic [7:0] r;
    for (int i = 0; i < 10; i++) d[i] = 8'hE0 + 8'(i);
    writeBurst(6'd2, d, 9);
    check("R10 overflow set", {7'b0, fifoOverflow}, 8'h01);
    csStart();
    xfer(8'h84, r);
    for (int i = 0; i < 8; i++) begin
      xfer((i == 7) ? 8'h00 : 8'h04, r);
      check("R10 kept entries in order", r, 8'hE0 + 8'(i));
    end
    csStop();
    readOne(6'd2, r); check("R10 ninth byte dropped", r, 8'h00);
    check("R10 overflow sticky", {7'b0, fifoOverflow}, 8'h01);
  endtask

  task automatic testAbort();
    logic [7:0] r, v;
    csStart(); xfer(8'h0E, r); xferBits(8'hFF, 4, r); csStop();
    readOne(6'd7, v); check("R11 partial data byte ignored", v, 8'h00);
    csStart(); xferBits(8'h80, 4, r); csStop();
    writeOne(6'd7, 8'h3C);
    readOne(6'd7, v); check("R11 fresh command after abort", v, 8'h3C);
    check("R11 miso low when idle", {7'b0, miso}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; sclk = 1'b0; csN = 1'b1; mosi = 1'b0;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    testReset();
    testBasicRW();
    testNoIncrement();
    testReserved();
    testPipeline();
    testZeroClose();
    testFifoOrder();
    testFifoOvf();
    testAbort();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule